// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block holds a small set of recently used page translations and resolves a virtual address against all of them at once. Each lookup compares the page number of the request with every resident tag in parallel, checks the access type (read or write) and the privilege level (supervisor or user) against the permission bits of the matching slot, and returns the physical address built from the stored frame number and the untouched page offset. The response is registered, so it appears one clock after the request.

When no slot matches, the block reports a miss, issues a one-cycle request to an external table walker carrying the page number, and holds itself busy until the walker answers. A successful answer is written into a slot. Empty slots are used first, and a circular pointer names the victim once every slot is occupied. A walker answer flagged as faulting is not stored and goes back to the requester as a page fault. A flush input drops every translation in one cycle. With the default 32 slots of 4 KiB pages the block covers 128 KiB at once. At 64 slots it covers 256 KiB.

Top module: `tlb_fa_top`

## Requirements
- R1: After reset no slot is valid, `busy`, `resp_valid` and `walk_req` are low, and the first lookup of any page reports a miss.
- R2: A lookup that matches a valid slot and is permitted gives `resp_valid` one clock later with `resp_kind` = 0 (hit) and `resp_paddr` = {stored frame number, request bits [PAGE_W-1:0]}.
- R3: A lookup that matches no valid slot gives `resp_kind` = 1 (miss) one clock later. In the same cycle `walk_req` is high for exactly one clock with `walk_vpn` equal to the request's page number, and `busy` is high. While `busy` is high, requests are ignored and produce no response.
- R4: A walker answer (`fill_valid` while busy) with `fill_fault` = 0 stores the page number, frame number and the four flag inputs into a slot and clears `busy`, with no response. A later lookup of that page hits.
- R5: A walker answer with `fill_fault` = 1 stores nothing and clears `busy`. One clock later it gives `resp_kind` = 3 (page fault), and a later lookup of that page misses again.
- R6: A read needs the slot's read flag and a write needs its write flag. In user mode (`req_user` = 1) the slot's user flag is also needed, while supervisor mode ignores it. A matching lookup that fails this test gives `resp_kind` = 2 (protection fault). For any result other than a hit, `resp_paddr` is 0.
- R7: On a hit, `resp_dirty` shows the slot's stored dirty flag as it was before the access. A permitted write hit sets that flag. Reads and refused writes leave it unchanged. `resp_dirty` is 0 for every result other than a hit.
- R8: `flush` clears every valid flag in one cycle, so that all later lookups miss. It leaves the replacement pointer where it was.
- R9: A stored answer goes into the lowest-numbered invalid slot. Only when every slot is valid does it overwrite the slot named by the replacement pointer, and only then does the pointer advance, wrapping from ENTRIES-1 to 0.
- R10: ENTRIES distinct pages can be resident together, and every one of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| busy | output | 1 | Miss outstanding; requests ignored |
| resp_valid | output | 1 | Response strobe |
| resp_kind | output | 2 | 0 hit, 1 miss, 2 protection fault, 3 page fault |
| resp_paddr | output | PA_W | Physical address on a hit, else 0 |
| resp_dirty | output | 1 | Dirty flag of the hit slot before the access |
| walk_req | output | 1 | One-cycle request to the table walker |
| walk_vpn | output | VA_W-PAGE_W | Page number to walk |
| fill_valid | input | 1 | Walker answer strobe |
| fill_fault | input | 1 | Walker found no valid mapping |
| fill_ppn | input | PA_W-PAGE_W | Frame number returned |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| fill_usr | input | 1 | User access permitted |
| fill_dirty | input | 1 | Initial dirty flag |

## Verification
A corrupt tag, frame or flag shows up at the first lookup of the affected page, one clock after that request, as a wrong kind, a wrong address or a wrong dirty flag. A replacement pointer that moves at the wrong time only shows when a slot is overwritten, so the bench fills the array to capacity, flushes it, refills it and checks which page was evicted. A busy flag that sticks shows as missing responses, and one that clears too early shows as a response to a request that should have been ignored.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic rd;
        logic wr;
        logic usr;
        logic dirty;
    } tlb_perm_t;

    localparam int unsigned TLB_PERM_W = $bits(tlb_perm_t);

    typedef enum logic [1:0] {
        TLB_HIT    = 2'd0,
        TLB_MISS   = 2'd1,
        TLB_PROT   = 2'd2,
        TLB_PFAULT = 2'd3
    } tlb_kind_e;

    function automatic logic tlb_access_ok(tlb_perm_t p, logic is_wr, logic is_usr);
        return (is_wr ? p.wr : p.rd) && (p.usr || !is_usr);
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    output tlb_perm_t          lk_perm,
    input  logic               dirty_set,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  tlb_perm_t          fill_perm,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0]    hit_vec;
    logic [PPN_W-1:0]      ppn_sel  [ENTRIES];
    logic [TLB_PERM_W-1:0] perm_sel [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v_q;
        logic [VPN_W-1:0] tag_q;
        logic [PPN_W-1:0] ppn_q;
        tlb_perm_t        perm_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q    <= 1'b0;
                tag_q  <= '0;
                ppn_q  <= '0;
                perm_q <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (fill_en && (fill_idx == IDX_W'(g))) begin
                v_q    <= 1'b1;
                tag_q  <= fill_vpn;
                ppn_q  <= fill_ppn;
                perm_q <= fill_perm;
            end else if (dirty_set && hit_vec[g]) begin
                perm_q.dirty <= 1'b1;
            end
        end

        assign hit_vec[g]   = v_q && (tag_q == lk_vpn);
        assign valid_vec[g] = v_q;
        assign ppn_sel[g]   = hit_vec[g] ? ppn_q : '0;
        assign perm_sel[g]  = hit_vec[g] ? perm_q : '0;
    end

    always_comb begin
        logic [TLB_PERM_W-1:0] perm_acc;
        lk_ppn   = '0;
        perm_acc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_ppn   = lk_ppn | ppn_sel[i];
            perm_acc = perm_acc | perm_sel[i];
        end
        lk_perm = tlb_perm_t'(perm_acc);
        lk_hit  = |hit_vec;
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R2

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0)); // R8

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               fill_en,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic             all_valid;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_found && !valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign all_valid  = &valid_vec;
    assign victim_idx = all_valid ? ptr_q : free_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (fill_en && all_valid) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(fill_en && all_valid) |=> $stable(ptr_q)); // R9

    AST_FREE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (fill_en && free_found) |=> valid_vec[$past(free_idx)]); // R9

endmodule

// File: rtl/tlb_fa_top.sv
module tlb_fa_top
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned PAGE_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   req_write,
    input  logic                   req_user,
    output logic                   busy,
    output logic                   resp_valid,
    output logic [1:0]             resp_kind,
    output logic [PA_W-1:0]        resp_paddr,
    output logic                   resp_dirty,
    output logic                   walk_req,
    output logic [VA_W-PAGE_W-1:0] walk_vpn,
    input  logic                   fill_valid,
    input  logic                   fill_fault,
    input  logic [PA_W-PAGE_W-1:0] fill_ppn,
    input  logic                   fill_rd,
    input  logic                   fill_wr,
    input  logic                   fill_usr,
    input  logic                   fill_dirty
);

    localparam int unsigned VPN_W = VA_W - PAGE_W;
    localparam int unsigned PPN_W = PA_W - PAGE_W;
    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]   req_vpn;
    logic [PAGE_W-1:0]  req_off;
    logic               lk_hit;
    logic [PPN_W-1:0]   lk_ppn;
    tlb_perm_t          lk_perm;
    logic               lk_ok;
    logic               accept;
    logic               dirty_set;
    logic               fill_go;
    logic               install;
    logic [IDX_W-1:0]   victim_idx;
    logic [ENTRIES-1:0] valid_vec;
    tlb_perm_t          fill_perm;

    logic               busy_q;
    logic               resp_valid_q;
    tlb_kind_e          resp_kind_q;
    logic [PA_W-1:0]    resp_paddr_q;
    logic               resp_dirty_q;
    logic               walk_req_q;
    logic [VPN_W-1:0]   pend_vpn_q;

    assign req_vpn   = req_vaddr[VA_W-1:PAGE_W];
    assign req_off   = req_vaddr[PAGE_W-1:0];
    assign accept    = req_valid && !busy_q && !flush;
    assign lk_ok     = tlb_access_ok(lk_perm, req_write, req_user);
    assign dirty_set = accept && lk_hit && lk_ok && req_write;
    assign fill_go   = fill_valid && busy_q;
    assign install   = fill_go && !fill_fault;

    always_comb begin
        fill_perm       = '0;
        fill_perm.rd    = fill_rd;
        fill_perm.wr    = fill_wr;
        fill_perm.usr   = fill_usr;
        fill_perm.dirty = fill_dirty;
    end

    tlb_store #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_vpn    (req_vpn),
        .lk_hit    (lk_hit),
        .lk_ppn    (lk_ppn),
        .lk_perm   (lk_perm),
        .dirty_set (dirty_set),
        .fill_en   (install),
        .fill_idx  (victim_idx),
        .fill_vpn  (pend_vpn_q),
        .fill_ppn  (fill_ppn),
        .fill_perm (fill_perm),
        .valid_vec (valid_vec)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk        (clk),
        .rst        (rst),
        .valid_vec  (valid_vec),
        .fill_en    (install),
        .victim_idx (victim_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_kind_q  <= TLB_HIT;
            resp_paddr_q <= '0;
            resp_dirty_q <= 1'b0;
            walk_req_q   <= 1'b0;
            pend_vpn_q   <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            walk_req_q   <= 1'b0;
            if (accept) begin
                resp_valid_q <= 1'b1;
                resp_paddr_q <= '0;
                resp_dirty_q <= 1'b0;
                if (lk_hit && lk_ok) begin
                    resp_kind_q  <= TLB_HIT;
                    resp_paddr_q <= {lk_ppn, req_off};
                    resp_dirty_q <= lk_perm.dirty;
                end else if (lk_hit) begin
                    resp_kind_q <= TLB_PROT;
                end else begin
                    resp_kind_q <= TLB_MISS;
                    busy_q      <= 1'b1;
                    pend_vpn_q  <= req_vpn;
                    walk_req_q  <= 1'b1;
                end
            end
            if (fill_go) begin
                busy_q <= 1'b0;
                if (fill_fault) begin
                    resp_valid_q <= 1'b1;
                    resp_kind_q  <= TLB_PFAULT;
                    resp_paddr_q <= '0;
                    resp_dirty_q <= 1'b0;
                end
            end
        end
    end

    assign busy       = busy_q;
    assign resp_valid = resp_valid_q;
    assign resp_kind  = resp_kind_q;
    assign resp_paddr = resp_paddr_q;
    assign resp_dirty = resp_dirty_q;
    assign walk_req   = walk_req_q;
    assign walk_vpn   = pend_vpn_q;

    AST_WALK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        walk_req_q |=> !walk_req_q); // R3

    AST_MISS_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_q && resp_kind_q == TLB_MISS) |-> busy_q); // R3

    AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (busy_q && fill_valid) |=> !busy_q); // R4

    AST_PFAULT_REPORT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && fill_valid && fill_fault) |=> (resp_valid_q && resp_kind_q == TLB_PFAULT)); // R5

    AST_NO_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_q && resp_kind_q != TLB_HIT) |-> (resp_paddr_q == '0 && !resp_dirty_q)); // R6

endmodule

// File: tb/tlb_fa_top_tb.sv
`timescale 1ns/1ps
module tlb_fa_top_tb;

    localparam int ENTRIES = 32;
    localparam int VA_W    = 32;
    localparam int PA_W    = 32;
    localparam int PAGE_W  = 12;
    localparam int VPN_W   = VA_W - PAGE_W;
    localparam int PPN_W   = PA_W - PAGE_W;

    localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_PROT = 2'd2, K_PF = 2'd3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             req_write = 1'b0;
    logic             req_user = 1'b0;
    logic             busy;
    logic             resp_valid;
    logic [1:0]       resp_kind;
    logic [PA_W-1:0]  resp_paddr;
    logic             resp_dirty;
    logic             walk_req;
    logic [VPN_W-1:0] walk_vpn;
    logic             fill_valid = 1'b0;
    logic             fill_fault = 1'b0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic             fill_rd = 1'b0;
    logic             fill_wr = 1'b0;
    logic             fill_usr = 1'b0;
    logic             fill_dirty = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    tlb_fa_top #(
        .ENTRIES (ENTRIES), .VA_W (VA_W), .PA_W (PA_W), .PAGE_W (PAGE_W)
    ) u_dut (
        .clk (clk), .rst (rst), .flush (flush),
        .req_valid (req_valid), .req_vaddr (req_vaddr),
        .req_write (req_write), .req_user (req_user),
        .busy (busy), .resp_valid (resp_valid), .resp_kind (resp_kind),
        .resp_paddr (resp_paddr), .resp_dirty (resp_dirty),
        .walk_req (walk_req), .walk_vpn (walk_vpn),
        .fill_valid (fill_valid), .fill_fault (fill_fault), .fill_ppn (fill_ppn),
        .fill_rd (fill_rd), .fill_wr (fill_wr), .fill_usr (fill_usr),
        .fill_dirty (fill_dirty)
    );

    typedef struct {
        logic [1:0]      kind;
        logic [PA_W-1:0] paddr;
        logic            dirty;
        logic [31:0]     tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic chk(input logic ok, input logic [31:0] tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Monitor: compare every response with the oldest expected item
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected response actual kind=%0d expected none", resp_kind);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (resp_kind !== e.kind || resp_paddr !== e.paddr || resp_dirty !== e.dirty) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d pa=0x%0h d=%0b expected kind=%0d pa=0x%0h d=%0b",
                             e.tag, resp_kind, resp_paddr, resp_dirty, e.kind, e.paddr, e.dirty);
                end
            end
        end
    end

    // Driver: one lookup, expected result pushed first
    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [PAGE_W-1:0] off,
                          input logic wr, input logic usr, input logic [1:0] kind,
                          input logic [PPN_W-1:0] ppn, input logic dirty, input logic [31:0] tag);
        exp_t e;
        e.kind  = kind;
        e.paddr = (kind == K_HIT) ? {ppn, off} : '0;
        e.dirty = (kind == K_HIT) ? dirty : 1'b0;
        e.tag   = tag;
        exp_q.push_back(e);
        req_valid = 1'b1;
        req_vaddr = {vpn, off};
        req_write = wr;
        req_user  = usr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic answer(input logic [PPN_W-1:0] ppn, input logic fault, input logic [31:0] tag);
        if (fault) begin
            exp_t e;
            e.kind = K_PF; e.paddr = '0; e.dirty = 1'b0; e.tag = tag;
            exp_q.push_back(e);
        end
        fill_valid = 1'b1;
        fill_fault = fault;
        fill_ppn   = ppn;
        fill_rd    = 1'b1;
        fill_wr    = 1'b1;
        fill_usr   = 1'b1;
        fill_dirty = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;
        fill_fault = 1'b0;
        chk(busy == 1'b0, "R4", busy, 0);
    endtask

    // Miss, walker request check, then answer with given flags
    task automatic miss_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                             input logic rd, input logic wr, input logic usr,
                             input logic fault, input logic [31:0] tag);
        lookup(vpn, 12'h0, 1'b0, 1'b0, K_MISS, '0, 1'b0, tag);
        chk(walk_req == 1'b1, "R3", walk_req, 1);
        chk(walk_vpn == vpn, "R3", walk_vpn, vpn);
        if (fault) begin
            answer(ppn, 1'b1, "R5");
        end else begin
            fill_valid = 1'b1; fill_fault = 1'b0; fill_ppn = ppn;
            fill_rd = rd; fill_wr = wr; fill_usr = usr; fill_dirty = 1'b0;
            @(negedge clk);
            fill_valid = 1'b0;
            chk(walk_req == 1'b0, "R3", walk_req, 0);
            chk(busy == 1'b0, "R4", busy, 0);
        end
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(resp_valid == 1'b0, "R1", resp_valid, 0);
        chk(walk_req == 1'b0, "R1", walk_req, 0);

        // R1/R4: first page misses, then installs
        miss_fill(20'h00100, 20'h000AB, 1'b1, 1'b1, 1'b1, 1'b0, "R1");
        // R2 hit address
        lookup(20'h00100, 12'h5A4, 1'b0, 1'b1, K_HIT, 20'h000AB, 1'b0, "R2");
        // R7 write hit reports old flag, then read shows it set
        lookup(20'h00100, 12'h010, 1'b1, 1'b1, K_HIT, 20'h000AB, 1'b0, "R7");
        lookup(20'h00100, 12'hFFF, 1'b0, 1'b1, K_HIT, 20'h000AB, 1'b1, "R7");

        // R6 read-only supervisor page
        miss_fill(20'h00200, 20'h00C0D, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        lookup(20'h00200, 12'h004, 1'b0, 1'b1, K_PROT, '0, 1'b0, "R6");
        lookup(20'h00200, 12'h008, 1'b0, 1'b0, K_HIT, 20'h00C0D, 1'b0, "R6");
        lookup(20'h00200, 12'h00C, 1'b1, 1'b0, K_PROT, '0, 1'b0, "R6");
        lookup(20'h00200, 12'h000, 1'b0, 1'b0, K_HIT, 20'h00C0D, 1'b0, "R7");

        // R5 faulting walk, with R3 request ignored while busy
        lookup(20'h00300, 12'h000, 1'b0, 1'b0, K_MISS, '0, 1'b0, "R3");
        chk(busy == 1'b1, "R3", busy, 1);
        req_valid = 1'b1; req_vaddr = {20'h00100, 12'h000}; req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        answer('0, 1'b1, "R5");
        @(negedge clk);
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        miss_fill(20'h00300, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R5");
        @(negedge clk);

        // R8 flush empties everything
        do_flush();
        miss_fill(20'h00100, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
        @(negedge clk);
        miss_fill(20'h00200, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
        @(negedge clk);

        // R10 fill to capacity
        for (int i = 0; i < ENTRIES; i++)
            miss_fill(20'h01000 + 20'(i), 20'h00500 + 20'(i), 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        for (int i = 0; i < ENTRIES; i++)
            lookup(20'h01000 + 20'(i), 12'h123, 1'b0, 1'b1, K_HIT, 20'h00500 + 20'(i), 1'b0, "R10");
        // R9 full: evicts the oldest (slot 0)
        miss_fill(20'h02000, 20'h00777, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        lookup(20'h02000, 12'h001, 1'b0, 1'b1, K_HIT, 20'h00777, 1'b0, "R9");
        lookup(20'h01001, 12'h001, 1'b0, 1'b1, K_HIT, 20'h00501, 1'b0, "R9");
        miss_fill(20'h01000, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        @(negedge clk);

        // R8/R9 pointer survives flush; free slots used first
        do_flush();
        for (int i = 0; i < ENTRIES; i++)
            miss_fill(20'h03000 + 20'(i), 20'h00900 + 20'(i), 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        lookup(20'h03000, 12'h0, 1'b0, 1'b1, K_HIT, 20'h00900, 1'b0, "R9");
        lookup(20'h03001, 12'h0, 1'b0, 1'b1, K_HIT, 20'h00901, 1'b0, "R9");
        miss_fill(20'h04000, 20'h00888, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        lookup(20'h03000, 12'h0, 1'b0, 1'b1, K_HIT, 20'h00900, 1'b0, "R8");
        lookup(20'h04000, 12'hABC, 1'b0, 1'b1, K_HIT, 20'h00888, 1'b0, "R9");
        miss_fill(20'h03001, '0, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        @(negedge clk);
        @(negedge clk);

        chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule